// File: doc/BRIEF.md
# Flash Code Protection Controller

This block keeps the one-way protection byte of an on-chip program store and enforces it on every path into that store. In programming mode a small command interface programs, reads and bulk-erases the store. The protection byte is reached at a reserved address on the same interface. Programming can only clear bits. Only the bulk erase can set them to 1 again, and it erases the store and the protection byte together.

In run mode the block screens table reads, which are constant fetches from code space. It checks where the issuing instruction lives and where the target address falls. The byte returned on the programming-mode data bus can be scrambled with a fixed XOR key. The block also exports a request for reduced oscillator gain, taken from one protection bit. A small register array stands in for the flash cells.

Top module: `fcp_top`

## Requirements
- R1: After reset every store cell and the protection byte read 0xFF, nothing drives the bus, and `osc_half_gain` is 0.
- R2: A program command (`pm_op`=01) at an address below `DEPTH` replaces the cell with old AND data. It never sets a bit. A read (`pm_op`=10) returns its result in the cycle after the command, for one cycle.
- R3: The protection byte sits at address 0xFFFF. Programming it only clears bits, so writing 1 to a bit that is already 0 leaves that bit at 0.
- R4: A bulk erase (`pm_op`=11) sets every store cell and every protection bit to 1.
- R5: While protection bit 0 (read lock) is 0, reads of the store and of the protection byte return 0xFF.
- R6: While protection bit 2 (scramble enable, active low) is 0, every unblocked read byte is XORed with the key 0xA5. Blocked reads still return 0xFF.
- R7: While `pm_oe_n` is high, `pm_drive` is 0 and `pm_rdata` is 0x00.
- R8: While protection bit 1 (table guard, active low) is 0, a table read with `rt_from_ext`=1 and a target below `DEPTH` is blocked. The result shows `rt_blocked`=1 and `rt_rdata`=0xFF.
- R9: A table read issued from internal code is always served. When bit 1 is 1, no table read is restricted. A target at or above `DEPTH` sets `rt_ext_sel` and returns 0xFF. Results appear the cycle after `rt_req`.
- R10: `osc_half_gain` is 1 exactly while protection bit 7 is 0.
- R11: Programming-mode commands have no effect while `prog_en` is low. A program command at an address that is neither a store cell nor 0xFFFF changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_en | input | 1 | 1 = programming mode, 0 = run mode |
| pm_op | input | 2 | Command: 00 idle, 01 program, 10 read, 11 bulk erase |
| pm_addr | input | ADDR_W | Programming-mode address |
| pm_wdata | input | 8 | Program data |
| pm_oe_n | input | 1 | Output enable, active low |
| pm_rdata | output | 8 | Data bus byte |
| pm_drive | output | 1 | Bus is being driven |
| rt_req | input | 1 | Table read request (run mode) |
| rt_addr | input | ADDR_W | Table read target address |
| rt_from_ext | input | 1 | Issuing instruction lies in external code |
| rt_valid | output | 1 | Table read result valid |
| rt_rdata | output | 8 | Table read data from the internal store |
| rt_ext_sel | output | 1 | Target lies in external memory |
| rt_blocked | output | 1 | Table read was refused |
| osc_half_gain | output | 1 | Reduced oscillator gain request |

## Verification
The bench checks that the protection bits move one way. Rewriting 0xFF to the protection byte must leave cleared bits cleared. A design that merged data by overwrite or OR would restore them. It checks that the read lock also hides the protection byte itself and that a blocked byte is not scrambled. A faulty design here would leak the protection byte or return 0x5A. Table reads are tried from both code spaces, with the guard bit set and clear and with targets on both sides of the store boundary, so a swapped origin or range test shows up as a wrong grant. The bench also confirms that bulk erase clears the gain request and the table guard.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } pm_op_e;

  localparam int SEC_LOCK_BIT = 0;
  localparam int SEC_TBL_BIT  = 1;
  localparam int SEC_ENC_BIT  = 2;
  localparam int SEC_GAIN_BIT = 7;

  localparam byte_t ERASED_BYTE  = 8'hFF;
  localparam byte_t BLOCKED_BYTE = 8'hFF;

  // one-way cell update: bits can only fall
  function automatic byte_t cell_program(byte_t old_v, byte_t new_v);
    return old_v & new_v;
  endfunction

  // bus scrambler: active when enc_n is 0
  function automatic byte_t bus_scramble(byte_t d, byte_t key, logic enc_n);
    return enc_n ? d : (d ^ key);
  endfunction

  // table read permission
  function automatic logic table_permit(logic from_ext, logic to_internal, logic guard_n);
    return !(from_ext && to_internal && !guard_n);
  endfunction
endpackage

// File: rtl/fcp_sec_reg.sv
module fcp_sec_reg
  import fcp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  prog_evt,
  input  logic  erase_evt,
  input  byte_t wdata,
  output byte_t sec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sec_q <= ERASED_BYTE;
    else if (erase_evt) sec_q <= ERASED_BYTE;
    else if (prog_evt)  sec_q <= cell_program(sec_q, wdata);
  end
endmodule

// File: rtl/fcp_array.sv
module fcp_array
  import fcp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_evt,
  input  logic             erase_evt,
  input  logic [IDX_W-1:0] waddr,
  input  byte_t            wdata,
  input  logic [IDX_W-1:0] raddr_a,
  input  logic [IDX_W-1:0] raddr_b,
  output byte_t            rdata_a,
  output byte_t            rdata_b
);
  byte_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 mem[i] <= ERASED_BYTE;
      else if (erase_evt)                         mem[i] <= ERASED_BYTE;
      else if (prog_evt && waddr == IDX_W'(i))    mem[i] <= cell_program(mem[i], wdata);
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fcp_prog_port.sv
module fcp_prog_port
  import fcp_pkg::*;
#(
  parameter byte_t KEY = 8'hA5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_evt,
  input  logic  hit_array,
  input  logic  hit_sec,
  input  byte_t array_data,
  input  byte_t sec_q,
  input  logic  oe_n,
  output byte_t pm_rdata,
  output logic  pm_drive,
  output logic  rd_blocked
);
  logic  valid_q;
  byte_t data_q;
  byte_t next_data;
  logic  next_blocked;

  always_comb begin
    next_blocked = 1'b0;
    next_data    = BLOCKED_BYTE;
    if (!sec_q[SEC_LOCK_BIT]) begin
      next_blocked = 1'b1;
    end else if (hit_array) begin
      next_data = bus_scramble(array_data, KEY, sec_q[SEC_ENC_BIT]);
    end else if (hit_sec) begin
      next_data = bus_scramble(sec_q, KEY, sec_q[SEC_ENC_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      data_q     <= '0;
      rd_blocked <= 1'b0;
    end else begin
      valid_q <= rd_evt;
      if (rd_evt) begin
        data_q     <= next_data;
        rd_blocked <= next_blocked;
      end
    end
  end

  assign pm_drive = valid_q && !oe_n;
  assign pm_rdata = pm_drive ? data_q : '0;
endmodule

// File: rtl/fcp_table_gate.sv
module fcp_table_gate
  import fcp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_evt,
  input  logic  in_range,
  input  logic  from_ext,
  input  logic  guard_n,
  input  byte_t array_data,
  output logic  rt_valid,
  output byte_t rt_rdata,
  output logic  rt_ext_sel,
  output logic  rt_blocked
);
  logic permit;
  assign permit = table_permit(from_ext, in_range, guard_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid   <= 1'b0;
      rt_rdata   <= BLOCKED_BYTE;
      rt_ext_sel <= 1'b0;
      rt_blocked <= 1'b0;
    end else begin
      rt_valid <= req_evt;
      if (req_evt) begin
        rt_blocked <= !permit;
        rt_ext_sel <= !in_range;
        rt_rdata   <= (in_range && permit) ? array_data : BLOCKED_BYTE;
      end
    end
  end
endmodule

// File: rtl/fcp_top.sv
module fcp_top
  import fcp_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DEPTH    = 64,
  parameter logic [7:0]  KEY      = 8'hA5,
  parameter logic [15:0] SEC_ADDR = 16'hFFFF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [1:0]        pm_op,
  input  logic [ADDR_W-1:0] pm_addr,
  input  logic [7:0]        pm_wdata,
  input  logic              pm_oe_n,
  output logic [7:0]        pm_rdata,
  output logic              pm_drive,
  input  logic              rt_req,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_from_ext,
  output logic              rt_valid,
  output logic [7:0]        rt_rdata,
  output logic              rt_ext_sel,
  output logic              rt_blocked,
  output logic              osc_half_gain
);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] SEC_A   = ADDR_W'(SEC_ADDR);

  pm_op_e op;
  assign op = pm_op_e'(pm_op);

  // named internal events
  logic  pm_in_array, pm_hit_sec, tbl_in_range;
  logic  prog_evt, array_prog, sec_prog, erase_evt, rd_evt, tbl_evt;
  logic  rd_blocked;
  byte_t sec_q, pm_cell, rt_cell;

  assign pm_in_array  = pm_addr < DEPTH_A;
  assign pm_hit_sec   = pm_addr == SEC_A;
  assign tbl_in_range = rt_addr < DEPTH_A;

  assign prog_evt   = prog_en && (op == OP_PROG);
  assign array_prog = prog_evt && pm_in_array;
  assign sec_prog   = prog_evt && pm_hit_sec;
  assign erase_evt  = prog_en && (op == OP_ERASE);
  assign rd_evt     = prog_en && (op == OP_READ);
  assign tbl_evt    = !prog_en && rt_req;

  fcp_sec_reg u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_evt  (sec_prog),
    .erase_evt (erase_evt),
    .wdata     (pm_wdata),
    .sec_q     (sec_q)
  );

  fcp_array #(.DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_evt  (array_prog),
    .erase_evt (erase_evt),
    .waddr     (pm_addr[IDX_W-1:0]),
    .wdata     (pm_wdata),
    .raddr_a   (pm_addr[IDX_W-1:0]),
    .raddr_b   (rt_addr[IDX_W-1:0]),
    .rdata_a   (pm_cell),
    .rdata_b   (rt_cell)
  );

  fcp_prog_port #(.KEY(KEY)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_evt     (rd_evt),
    .hit_array  (pm_in_array),
    .hit_sec    (pm_hit_sec),
    .array_data (pm_cell),
    .sec_q      (sec_q),
    .oe_n       (pm_oe_n),
    .pm_rdata   (pm_rdata),
    .pm_drive   (pm_drive),
    .rd_blocked (rd_blocked)
  );

  fcp_table_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_evt    (tbl_evt),
    .in_range   (tbl_in_range),
    .from_ext   (rt_from_ext),
    .guard_n    (sec_q[SEC_TBL_BIT]),
    .array_data (rt_cell),
    .rt_valid   (rt_valid),
    .rt_rdata   (rt_rdata),
    .rt_ext_sel (rt_ext_sel),
    .rt_blocked (rt_blocked)
  );

  assign osc_half_gain = !sec_q[SEC_GAIN_BIT];
endmodule

// File: rtl/fcp_checks.sv
module fcp_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       erase_evt,
  input logic       tbl_evt,
  input logic       tbl_in_range,
  input logic       rt_from_ext,
  input logic [7:0] sec_q,
  input logic       pm_oe_n,
  input logic       pm_drive,
  input logic [7:0] pm_rdata,
  input logic       rt_blocked,
  input logic [7:0] rt_rdata
);
  // R3: no protection bit rises without a bulk erase
  assert_sec_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_evt |=> ((sec_q & ~$past(sec_q)) == 8'h00));

  // R4: bulk erase leaves every protection bit at 1
  assert_erase_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_evt |=> (sec_q == 8'hFF));

  // R5: a driven read under lock shows only the blocked byte
  assert_lock_hides_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_drive && !sec_q[0]) |-> (pm_rdata == 8'hFF));

  // R7: output enable high keeps the bus released
  assert_oe_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_oe_n |-> (!pm_drive && pm_rdata == 8'h00));

  // R8: guarded table read from external code is refused
  assert_table_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_evt && rt_from_ext && tbl_in_range && !sec_q[1]) |=> (rt_blocked && rt_rdata == 8'hFF));
endmodule

bind fcp_top fcp_checks u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .erase_evt    (erase_evt),
  .tbl_evt      (tbl_evt),
  .tbl_in_range (tbl_in_range),
  .rt_from_ext  (rt_from_ext),
  .sec_q        (sec_q),
  .pm_oe_n      (pm_oe_n),
  .pm_drive     (pm_drive),
  .pm_rdata     (pm_rdata),
  .rt_blocked   (rt_blocked),
  .rt_rdata     (rt_rdata)
);

// File: tb/tb_fcp_top.sv
module tb_fcp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_en = 1'b1;
  logic [1:0]  pm_op = 2'b00;
  logic [15:0] pm_addr = '0;
  logic [7:0]  pm_wdata = '0;
  logic        pm_oe_n = 1'b0;
  logic [7:0]  pm_rdata;
  logic        pm_drive;
  logic        rt_req = 1'b0;
  logic [15:0] rt_addr = '0;
  logic        rt_from_ext = 1'b0;
  logic        rt_valid;
  logic [7:0]  rt_rdata;
  logic        rt_ext_sel;
  logic        rt_blocked;
  logic        osc_half_gain;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  localparam logic [7:0] KEY = 8'hA5;
  localparam logic [15:0] SEC = 16'hFFFF;

  always #2.5 clk = ~clk;

  fcp_top dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .pm_op(pm_op),
    .pm_addr(pm_addr), .pm_wdata(pm_wdata), .pm_oe_n(pm_oe_n),
    .pm_rdata(pm_rdata), .pm_drive(pm_drive), .rt_req(rt_req),
    .rt_addr(rt_addr), .rt_from_ext(rt_from_ext), .rt_valid(rt_valid),
    .rt_rdata(rt_rdata), .rt_ext_sel(rt_ext_sel), .rt_blocked(rt_blocked),
    .osc_half_gain(osc_half_gain)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic pm_cmd(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    pm_op = op; pm_addr = a; pm_wdata = d;
    @(negedge clk);
    pm_op = 2'b00;
  endtask

  task automatic pm_read(input logic [15:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk);
    pm_op = 2'b10; pm_addr = a;
    @(negedge clk);
    d = pm_rdata; drv = pm_drive;
    pm_op = 2'b00;
  endtask

  task automatic tbl_read(input logic [15:0] a, input logic ext,
                          output logic [7:0] d, output logic blk, output logic xs);
    @(negedge clk);
    prog_en = 1'b0; rt_req = 1'b1; rt_addr = a; rt_from_ext = ext;
    @(negedge clk);
    d = rt_rdata; blk = rt_blocked; xs = rt_ext_sel;
    checks++;
    if (rt_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: rt_valid got %b expected 1", rt_valid);
    end
    rt_req = 1'b0; prog_en = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    check("R1 no drive", {7'd0, pm_drive}, 8'h00);
    check("R1 gain", {7'd0, osc_half_gain}, 8'h00);
    pm_read(16'd0, d, v);  check("R1 cell0", d, 8'hFF);
    pm_read(16'd63, d, v); check("R1 cell63", d, 8'hFF);
    pm_read(SEC, d, v);    check("R1 sec", d, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] d; logic v;
    pm_cmd(2'b01, 16'd3, 8'h3C);
    pm_read(16'd3, d, v); check("R2 first program", d, 8'h3C);
    check("R2 drive on read", {7'd0, v}, 8'h01);
    pm_cmd(2'b01, 16'd3, 8'hF0);
    pm_read(16'd3, d, v); check("R2 AND merge", d, 8'h30);
    pm_cmd(2'b01, 16'd63, 8'h5A);
    pm_read(16'd63, d, v); check("R2 top cell", d, 8'h5A);
    @(negedge clk);
    check("R2 one-cycle result", {7'd0, pm_drive}, 8'h00);
  endtask

  task automatic t_oe();
    logic [7:0] d; logic v;
    pm_oe_n = 1'b1;
    pm_read(16'd3, d, v);
    check("R7 drive", {7'd0, v}, 8'h00);
    check("R7 data", d, 8'h00);
    pm_oe_n = 1'b0;
  endtask

  task automatic t_ignored();
    logic [7:0] d; logic v;
    @(negedge clk);
    prog_en = 1'b0; pm_op = 2'b01; pm_addr = 16'd4; pm_wdata = 8'h00;
    @(negedge clk);
    pm_op = 2'b11;
    @(negedge clk);
    pm_op = 2'b00; prog_en = 1'b1;
    pm_read(16'd4, d, v); check("R11 prog_en low", d, 8'hFF);
    pm_read(16'd3, d, v); check("R11 no erase when off", d, 8'h30);
    pm_cmd(2'b01, 16'd100, 8'h00);
    pm_read(16'd100, d, v); check("R11 out of range", d, 8'hFF);
    pm_read(SEC, d, v);     check("R11 sec untouched", d, 8'hFF);
  endtask

  task automatic t_table();
    logic [7:0] d; logic b, x, v;
    tbl_read(16'd3, 1'b1, d, b, x);
    check("R9 unguarded ext data", d, 8'h30);
    check("R9 unguarded not blocked", {7'd0, b}, 8'h00);
    pm_cmd(2'b01, SEC, 8'hFD);
    pm_read(SEC, d, v); check("R3 sec programmed", d, 8'hFD);
    tbl_read(16'd3, 1'b1, d, b, x);
    check("R8 blocked flag", {7'd0, b}, 8'h01);
    check("R8 blocked data", d, 8'hFF);
    tbl_read(16'd3, 1'b0, d, b, x);
    check("R9 internal origin data", d, 8'h30);
    check("R9 internal origin flag", {7'd0, b}, 8'h00);
    tbl_read(16'd200, 1'b1, d, b, x);
    check("R9 external target sel", {7'd0, x}, 8'h01);
    check("R9 external target not blocked", {7'd0, b}, 8'h00);
    tbl_read(16'd63, 1'b1, d, b, x);
    check("R8 last internal cell blocked", {7'd0, b}, 8'h01);
  endtask

  task automatic t_sec();
    logic [7:0] d; logic v;
    pm_cmd(2'b01, SEC, 8'hFF);
    pm_read(SEC, d, v); check("R3 one-way", d, 8'hFD);
    check("R10 gain off", {7'd0, osc_half_gain}, 8'h00);
    pm_cmd(2'b01, SEC, 8'h7F);
    pm_read(SEC, d, v); check("R3 bit7 cleared", d, 8'h7D);
    check("R10 gain on", {7'd0, osc_half_gain}, 8'h01);
  endtask

  task automatic t_encrypt();
    logic [7:0] d; logic v;
    pm_cmd(2'b01, SEC, 8'hFB);
    pm_read(SEC, d, v);     check("R6 sec scrambled", d, 8'h79 ^ KEY);
    pm_read(16'd3, d, v);   check("R6 cell scrambled", d, 8'h30 ^ KEY);
    pm_read(16'd100, d, v); check("R6 unmapped scrambled-free", d, 8'hFF);
  endtask

  task automatic t_lock();
    logic [7:0] d; logic v;
    pm_cmd(2'b01, SEC, 8'hFE);
    pm_read(16'd3, d, v); check("R5 cell locked", d, 8'hFF);
    pm_read(SEC, d, v);   check("R5 sec locked", d, 8'hFF);
    check("R5 still drives", {7'd0, v}, 8'h01);
  endtask

  task automatic t_erase();
    logic [7:0] d; logic b, x, v;
    pm_cmd(2'b11, 16'd0, 8'h00);
    pm_read(SEC, d, v);    check("R4 sec erased", d, 8'hFF);
    pm_read(16'd3, d, v);  check("R4 cell3 erased", d, 8'hFF);
    pm_read(16'd63, d, v); check("R4 cell63 erased", d, 8'hFF);
    check("R4 gain released", {7'd0, osc_half_gain}, 8'h00);
    tbl_read(16'd3, 1'b1, d, b, x);
    check("R4 guard released", {7'd0, b}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_oe();
    t_ignored();
    t_table();
    t_sec();
    t_encrypt();
    t_lock();
    t_erase();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule